// File: doc/BRIEF.md
# Timer Clock Source Selector

This block produces two clock-enable strobes, one for a time-base counter and one for a real-time / periodic-interrupt counter. Both run in the system clock domain. Each strobe is made by choosing one of four reference tick strobes and counting its ticks up to a programmable ratio. The four references are an oscillator tick, an external-clock tick, a system-clock tick and a backup-oscillator tick. When the counted ticks reach the ratio, the block emits one enable pulse, one system-clock cycle wide.

The choice of reference depends on three things: a limp-mode status flag, a backup-disable override bit and a set of configuration bits.

- In limp mode the backup tick drives both channels, unless the override bit forbids it.
- Outside limp mode, or when the override is set, the time base uses either the oscillator or the system tick.
- In the same case, the real-time channel uses either the oscillator (crystal) tick or the external-clock tick.

Two settings are taken from mode-pin samples during the power-on reset:

- the time-base oscillator ratio;
- the reset value of the real-time divider bit.

Any change of the effective source or ratio clears the prescaler, so that no strobe comes out from a mix of two settings.

Top module: `tcs_top`

## Requirements
- R1: While limp_active=1 and bkp_dis=0, both channels count bkp_tick. The time base divides it by TB_BKP_DIV (16). The real-time channel divides it by its current ratio (R6).
- R2: While bkp_dis=1, bkp_tick is never counted. The real-time channel counts ext_tick when rtc_ext_sel=1 and osc_tick when rtc_ext_sel=0.
- R3: Outside R1, with tb_src_sys=0, the time base counts osc_tick. It divides by 4 when the strapped mode_pin[0] was 0 and by 16 when it was 1.
- R4: Outside R1, with tb_src_sys=1, the time base counts sys_tick and divides it by 16.
- R5: Under the R1 condition, tb_src_sys has no effect on tb_en. Toggling it neither changes the strobe timing nor restarts the count.
- R6: The real-time divider bit selects the ratio: 0 selects divide-by-4 and 1 selects divide-by-256.
- R7: During rst the real-time divider bit loads 0 if mode_pin[2:0] are all 0, and loads 1 otherwise. After reset, a cycle with rtc_div_we=1 loads rtc_div_wdata, which takes effect from the next cycle.
- R8: In a cycle where a channel's effective source or ratio differs from the previous cycle, that channel's count is cleared and the tick in that cycle is not counted. No strobe follows in the next cycle.
- R9: A strobe goes high in the cycle after the N-th counted tick (N is the ratio). It is high for exactly one cycle, and the count then starts again from zero. Both strobes are 0 during and straight after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset; mode pins are sampled while high |
| osc_tick | input | 1 | Oscillator (crystal) tick strobe |
| ext_tick | input | 1 | External-clock tick strobe |
| sys_tick | input | 1 | System-clock tick strobe |
| bkp_tick | input | 1 | Backup-oscillator tick strobe |
| limp_active | input | 1 | Limp-mode status |
| bkp_dis | input | 1 | 1 = timers never use the backup tick |
| tb_src_sys | input | 1 | Time-base source: 0 oscillator, 1 system tick |
| rtc_ext_sel | input | 1 | Real-time source: 0 oscillator, 1 external clock |
| rtc_div_we | input | 1 | Write strobe for the real-time divider bit |
| rtc_div_wdata | input | 1 | Value written to the real-time divider bit |
| mode_pin | input | 3 | Mode-pin samples, bit 0 = pin 1 |
| tb_en | output | 1 | Time-base enable strobe |
| rtc_en | output | 1 | Real-time / periodic-interrupt enable strobe |

## Verification
The bench builds the block with its default ratios (4, 16 and 256, with an 8-bit prescaler). This keeps the long divide-by-256 real-time period within a short run. It also leaves room to switch sources in the middle of a count many times. Resets with mode-pin patterns 000, 001 and 100 reach both strap outcomes of the divider bit and both oscillator ratios. Random tick densities on all four references expose any strobe that comes from the wrong source.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    SRC_OSC = 2'd0,
    SRC_EXT = 2'd1,
    SRC_SYS = 2'd2,
    SRC_BKP = 2'd3
  } tick_src_e;

  localparam int NUM_CHAN = 2;
  localparam int CH_TB    = 0;
  localparam int CH_RTC   = 1;

  function automatic logic pick_tick(input tick_src_e s, input logic [3:0] ticks);
    return ticks[s];
  endfunction
endpackage

// File: rtl/tcs_strap.sv
module tcs_strap (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] mode_pin,
  input  logic       rtc_div_we,
  input  logic       rtc_div_wdata,
  output logic       mp1_q,
  output logic       rtc_div_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mp1_q     <= mode_pin[0];
      rtc_div_q <= |mode_pin;
    end else if (rtc_div_we) begin
      rtc_div_q <= rtc_div_wdata;
    end
  end

  AST_DIV_WRITE: assert property (@(posedge clk) disable iff (rst)
    rtc_div_we |=> rtc_div_q == $past(rtc_div_wdata)); // R7

  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mp1_q)); // R3
endmodule

// File: rtl/tcs_route.sv
module tcs_route
  import tcs_pkg::*;
#(
  parameter int TB_OSC_DIV_A = 4,
  parameter int TB_OSC_DIV_B = 16,
  parameter int TB_SYS_DIV   = 16,
  parameter int TB_BKP_DIV   = 16,
  parameter int RTC_DIV_A    = 4,
  parameter int RTC_DIV_B    = 256,
  parameter int CNT_W        = 8
) (
  input  logic             limp_active,
  input  logic             bkp_dis,
  input  logic             tb_src_sys,
  input  logic             rtc_ext_sel,
  input  logic             mp1,
  input  logic             rtc_div,
  output tick_src_e        src_o [NUM_CHAN],
  output logic [CNT_W-1:0] lim_o [NUM_CHAN]
);
  localparam logic [CNT_W-1:0] L_TB_OSC_A = CNT_W'(TB_OSC_DIV_A - 1);
  localparam logic [CNT_W-1:0] L_TB_OSC_B = CNT_W'(TB_OSC_DIV_B - 1);
  localparam logic [CNT_W-1:0] L_TB_SYS   = CNT_W'(TB_SYS_DIV - 1);
  localparam logic [CNT_W-1:0] L_TB_BKP   = CNT_W'(TB_BKP_DIV - 1);
  localparam logic [CNT_W-1:0] L_RTC_A    = CNT_W'(RTC_DIV_A - 1);
  localparam logic [CNT_W-1:0] L_RTC_B    = CNT_W'(RTC_DIV_B - 1);

  logic use_bkp;
  assign use_bkp = limp_active && !bkp_dis;

  always_comb begin
    if (use_bkp) begin
      src_o[CH_TB] = SRC_BKP;
      lim_o[CH_TB] = L_TB_BKP;
    end else if (tb_src_sys) begin
      src_o[CH_TB] = SRC_SYS;
      lim_o[CH_TB] = L_TB_SYS;
    end else begin
      src_o[CH_TB] = SRC_OSC;
      lim_o[CH_TB] = mp1 ? L_TB_OSC_B : L_TB_OSC_A;
    end
  end

  always_comb begin
    if (use_bkp)          src_o[CH_RTC] = SRC_BKP;
    else if (rtc_ext_sel) src_o[CH_RTC] = SRC_EXT;
    else                  src_o[CH_RTC] = SRC_OSC;
    lim_o[CH_RTC] = rtc_div ? L_RTC_B : L_RTC_A;
  end
endmodule

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int CNT_W = 8,
  parameter int KEY_W = CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [KEY_W-1:0] key,
  input  logic [CNT_W-1:0] limit,
  output logic             en_o
);
  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] cnt_q;
  logic             restart;

  assign restart = (key != key_q);

  always_ff @(posedge clk) begin
    key_q <= key;
    if (rst || restart) begin
      cnt_q <= '0;
      en_o  <= 1'b0;
    end else if (tick) begin
      if (cnt_q >= limit) begin
        cnt_q <= '0;
        en_o  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        en_o  <= 1'b0;
      end
    end else begin
      en_o <= 1'b0;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    en_o |=> !en_o); // R9
  AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!en_o && cnt_q == '0)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    !restart |-> cnt_q <= limit); // R9
  AST_PULSE_HAS_TICK: assert property (@(posedge clk) disable iff (rst)
    en_o |-> $past(tick)); // R9
endmodule

// File: rtl/tcs_top.sv
module tcs_top
  import tcs_pkg::*;
#(
  parameter int TB_OSC_DIV_A = 4,
  parameter int TB_OSC_DIV_B = 16,
  parameter int TB_SYS_DIV   = 16,
  parameter int TB_BKP_DIV   = 16,
  parameter int RTC_DIV_A    = 4,
  parameter int RTC_DIV_B    = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       osc_tick,
  input  logic       ext_tick,
  input  logic       sys_tick,
  input  logic       bkp_tick,
  input  logic       limp_active,
  input  logic       bkp_dis,
  input  logic       tb_src_sys,
  input  logic       rtc_ext_sel,
  input  logic       rtc_div_we,
  input  logic       rtc_div_wdata,
  input  logic [2:0] mode_pin,
  output logic       tb_en,
  output logic       rtc_en
);
  localparam int MAX_A   = (TB_OSC_DIV_A > TB_OSC_DIV_B) ? TB_OSC_DIV_A : TB_OSC_DIV_B;
  localparam int MAX_B   = (TB_SYS_DIV > TB_BKP_DIV) ? TB_SYS_DIV : TB_BKP_DIV;
  localparam int MAX_C   = (RTC_DIV_A > RTC_DIV_B) ? RTC_DIV_A : RTC_DIV_B;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_DIV = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
  localparam int CNT_W   = (MAX_DIV > 2) ? $clog2(MAX_DIV) : 1;
  localparam int KEY_W   = CNT_W + 2;

  logic             mp1_q;
  logic             rtc_div_q;
  tick_src_e        src   [NUM_CHAN];
  logic [CNT_W-1:0] lim   [NUM_CHAN];
  logic [NUM_CHAN-1:0] en_w;
  logic [3:0]       ticks;

  assign ticks = {bkp_tick, sys_tick, ext_tick, osc_tick};

  tcs_strap u_strap (
    .clk           (clk),
    .rst           (rst),
    .mode_pin      (mode_pin),
    .rtc_div_we    (rtc_div_we),
    .rtc_div_wdata (rtc_div_wdata),
    .mp1_q         (mp1_q),
    .rtc_div_q     (rtc_div_q)
  );

  tcs_route #(
    .TB_OSC_DIV_A (TB_OSC_DIV_A),
    .TB_OSC_DIV_B (TB_OSC_DIV_B),
    .TB_SYS_DIV   (TB_SYS_DIV),
    .TB_BKP_DIV   (TB_BKP_DIV),
    .RTC_DIV_A    (RTC_DIV_A),
    .RTC_DIV_B    (RTC_DIV_B),
    .CNT_W        (CNT_W)
  ) u_route (
    .limp_active (limp_active),
    .bkp_dis     (bkp_dis),
    .tb_src_sys  (tb_src_sys),
    .rtc_ext_sel (rtc_ext_sel),
    .mp1         (mp1_q),
    .rtc_div     (rtc_div_q),
    .src_o       (src),
    .lim_o       (lim)
  );

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic             chan_tick;
    logic [KEY_W-1:0] chan_key;
    assign chan_tick = pick_tick(src[c], ticks);
    assign chan_key  = {src[c], lim[c]};
    tcs_prescaler #(.CNT_W(CNT_W), .KEY_W(KEY_W)) u_ps (
      .clk   (clk),
      .rst   (rst),
      .tick  (chan_tick),
      .key   (chan_key),
      .limit (lim[c]),
      .en_o  (en_w[c])
    );
  end

  assign tb_en  = en_w[CH_TB];
  assign rtc_en = en_w[CH_RTC];

  AST_LIMP_TB_BKP: assert property (@(posedge clk) disable iff (rst)
    (tb_en && $past(limp_active && !bkp_dis)) |-> $past(bkp_tick)); // R1
  AST_LIMP_RTC_BKP: assert property (@(posedge clk) disable iff (rst)
    (rtc_en && $past(limp_active && !bkp_dis)) |-> $past(bkp_tick)); // R1
  AST_DIS_RTC_SRC: assert property (@(posedge clk) disable iff (rst)
    (rtc_en && $past(bkp_dis)) |-> $past(rtc_ext_sel ? ext_tick : osc_tick)); // R2
  AST_TB_SYS_SRC: assert property (@(posedge clk) disable iff (rst)
    (tb_en && $past(tb_src_sys && !(limp_active && !bkp_dis))) |-> $past(sys_tick)); // R4
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!tb_en && !rtc_en)); // R9
endmodule

// File: tb/tcs_top_tb_top.sv
module tcs_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_tick = 0, ext_tick = 0, sys_tick = 0, bkp_tick = 0;
  logic limp_active = 0, bkp_dis = 0, tb_src_sys = 0, rtc_ext_sel = 0;
  logic rtc_div_we = 0, rtc_div_wdata = 0;
  logic [2:0] mode_pin = 3'b000;
  logic tb_en, rtc_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcs_top dut_i (
    .clk(clk), .rst(rst), .osc_tick(osc_tick), .ext_tick(ext_tick),
    .sys_tick(sys_tick), .bkp_tick(bkp_tick), .limp_active(limp_active),
    .bkp_dis(bkp_dis), .tb_src_sys(tb_src_sys), .rtc_ext_sel(rtc_ext_sel),
    .rtc_div_we(rtc_div_we), .rtc_div_wdata(rtc_div_wdata),
    .mode_pin(mode_pin), .tb_en(tb_en), .rtc_en(rtc_en)
  );

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R9";
  bit done = 0;

  // Behavioural reference model
  bit m_mp1, m_rdiv;
  int m_cnt [2];
  int m_prev [2];
  bit m_en [2];
  int m_src [2];
  int m_div [2];
  int m_key;
  bit m_tk;

  function automatic bit tick_of(int s);
    case (s)
      0: return osc_tick;
      1: return ext_tick;
      2: return sys_tick;
      default: return bkp_tick;
    endcase
  endfunction

  always @(posedge clk) begin
    if (limp_active && !bkp_dis) begin
      m_src[0] = 3; m_div[0] = 16; m_src[1] = 3;
    end else begin
      if (tb_src_sys) begin m_src[0] = 2; m_div[0] = 16; end
      else begin m_src[0] = 0; m_div[0] = m_mp1 ? 16 : 4; end
      m_src[1] = rtc_ext_sel ? 1 : 0;
    end
    m_div[1] = m_rdiv ? 256 : 4;
    for (int c = 0; c < 2; c++) begin
      m_key = m_src[c] * 1024 + m_div[c];
      m_tk  = tick_of(m_src[c]);
      if (rst || m_key != m_prev[c]) begin
        m_cnt[c] = 0; m_en[c] = 0;
      end else if (m_tk) begin
        if (m_cnt[c] == m_div[c] - 1) begin m_cnt[c] = 0; m_en[c] = 1; end
        else begin m_cnt[c] = m_cnt[c] + 1; m_en[c] = 0; end
      end else begin
        m_en[c] = 0;
      end
      m_prev[c] = m_key;
    end
    if (rst) begin
      m_mp1  = mode_pin[0];
      m_rdiv = |mode_pin;
    end else if (rtc_div_we) begin
      m_rdiv = rtc_div_wdata;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_vec++;
      if (tb_en !== m_en[0]) begin
        n_bad++;
        $display("FAIL %s tb_en actual=%0b expected=%0b t=%0t", cur_req, tb_en, m_en[0], $time);
      end
      if (rtc_en !== m_en[1]) begin
        n_bad++;
        $display("FAIL %s rtc_en actual=%0b expected=%0b t=%0t", cur_req, rtc_en, m_en[1], $time);
      end
    end
  end

  // Tick densities in percent
  int d_osc = 0, d_ext = 0, d_sys = 0, d_bkp = 0;

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      osc_tick = ($urandom_range(0, 99) < d_osc);
      ext_tick = ($urandom_range(0, 99) < d_ext);
      sys_tick = ($urandom_range(0, 99) < d_sys);
      bkp_tick = ($urandom_range(0, 99) < d_bkp);
      rtc_div_we = 0;
    end
  endtask

  task automatic do_reset(logic [2:0] pins);
    @(posedge clk); #2;
    rst = 1; mode_pin = pins;
    cyc(3);
    @(posedge clk); #2;
    rst = 0;
  endtask

  // Pulse counting check: tb_en count over a window with ticks every cycle
  task automatic count_tb(int cycles, int expect_n, string req);
    int got;
    got = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tb_en) got++;
    end
    n_vec++;
    if (got != expect_n) begin
      n_bad++;
      $display("FAIL %s tb_en pulse count actual=%0d expected=%0d", req, got, expect_n);
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R9 / R7: reset state, pins 000 -> divider bit 0, osc ratio /4
    cur_req = "R9";
    do_reset(3'b000);
    cur_req = "R3";
    d_osc = 100; d_ext = 30; d_sys = 30; d_bkp = 30;
    cyc(5);
    // osc ticks every cycle, /4: 10 pulses in 40 cycles
    count_tb(40, 10, "R3");
    cyc(40);
    cur_req = "R6";
    cyc(60);           // rtc /4 on osc (R6, R7 strap 0)
    cur_req = "R7";
    @(posedge clk); #2; rtc_div_we = 1; rtc_div_wdata = 1;
    cyc(600);          // rtc /256
    cur_req = "R4";
    tb_src_sys = 1; d_sys = 100;
    cyc(4);
    count_tb(64, 4, "R4");
    d_sys = 60;
    cyc(200);
    cur_req = "R1";
    limp_active = 1; bkp_dis = 0; d_bkp = 70; d_osc = 50; d_ext = 50;
    @(posedge clk); #2; rtc_div_we = 1; rtc_div_wdata = 0;
    cyc(300);
    cur_req = "R5";
    for (int k = 0; k < 40; k++) begin
      tb_src_sys = ~tb_src_sys;
      cyc(7);
    end
    d_bkp = 100; d_osc = 0; d_sys = 0;
    cyc(3);
    for (int k = 0; k < 8; k++) begin
      tb_src_sys = ~tb_src_sys;
      count_tb(16, 1, "R5");
    end
    cur_req = "R2";
    bkp_dis = 1; rtc_ext_sel = 1; d_ext = 60; d_osc = 40; d_bkp = 100; d_sys = 50;
    cyc(300);
    rtc_ext_sel = 0;
    cyc(200);
    limp_active = 0;
    cyc(100);
    cur_req = "R8";
    d_osc = 100; d_ext = 100; d_sys = 100; d_bkp = 100;
    for (int k = 0; k < 60; k++) begin
      rtc_ext_sel = ~rtc_ext_sel;
      if (k % 3 == 0) tb_src_sys = ~tb_src_sys;
      if (k % 5 == 0) limp_active = ~limp_active;
      if (k % 7 == 0) bkp_dis = ~bkp_dis;
      cyc(k % 6 + 1);
    end
    limp_active = 0; bkp_dis = 0; tb_src_sys = 0;
    cyc(2);
    tb_src_sys = 1;
    count_tb(3, 0, "R8");
    cur_req = "R7";
    tb_src_sys = 0; rtc_ext_sel = 0;
    do_reset(3'b001);   // mp1=1 -> osc /16, divider bit 1
    cur_req = "R3";
    cyc(3);
    count_tb(64, 4, "R3");
    cyc(600);
    cur_req = "R7";
    do_reset(3'b100);   // mp1=0, divider bit 1
    d_osc = 70;
    cyc(1200);
    cur_req = "R6";
    @(posedge clk); #2; rtc_div_we = 1; rtc_div_wdata = 0;
    cyc(100);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule